// File: doc/BRIEF.md
# Overlay Fade Line-Mask Sequencer

This block decides, scanline by scanline, whether an on-screen display overlay is drawn. It lets the overlay appear or disappear gradually over many video frames. The screen is cut vertically into repeating bands of 16 scanlines. The position of the current line inside its band comes from an absolute line counter, which is cleared at each frame start and advanced by a horizontal line strobe. It is not tied to character-row boundaries, so a row may straddle two bands.

A fade passes through five levels. At each level the number of lit lines per band doubles (1, 2, 4, 8, 16), and each level lasts 32 frames. A line is lit when the bit-reversed form of its 4-bit in-band index is below the current lit count. This spreads the lit lines evenly, makes each level a superset of the one below it, and makes fade-out the exact mirror of fade-in.

The on/off request and the fade-enable bit are sampled only at a frame start. When fading is disabled, the display jumps straight to its final state. While the overlay is dark, the color outputs are driven to all zeros and are never released.

Top module: `osd_fade_seq`

## Requirements
- R1: After reset, and while reset is held low, `line_en_o` is 0, `busy_o` is 0 and `color_o` is all zeros.
- R2: A frame starts on the rising edge of `vflbk_i ^ vflbk_low_i`. With the select clear the flyback input is active high; with it set the input is active low. The inactive-going edge of the input does not start a frame.
- R3: The in-band line index is 0 after a frame start. It advances by one on each cycle with `line_stb_i` high and wraps from 15 to 0.
- R4: The fade level L runs from 0 to 5, with a lit count of 0 at L=0 and 2^(L-1) otherwise. Line index i (bits i3..i0) is lit when the value {i0,i1,i2,i3} is less than that count. For example, L=1 lights only index 0, L=2 lights 0 and 8, L=4 lights every even index, and L=5 lights all lines.
- R5: With fading enabled and display on requested, the level rises by one every 32 frames. The frame start that latches the new request counts as the first frame. The level reaches 1 at the 32nd frame start and 5 at the 160th.
- R6: With fading enabled and display off requested from level 5, the number of blanked lines per band goes 8, 12, 14, 15, 16, with one step every 32 frames.
- R7: With fading disabled, the level jumps to 5 (on) or 0 (off) at the first frame start that samples the request.
- R8: Changes on `disp_on_i` and `fade_en_i` have no effect on any output until the next frame start.
- R9: A request reversal during a fade continues from the current level in the new direction. The reversing frame start counts as the first of 32 frames.
- R10: `busy_o` is 1 exactly when the level differs from the target of the last latched request (5 for on, 0 for off).
- R11: `color_o` equals `color_i` on a lit line and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vflbk_i | input | 1 | Vertical flyback input |
| vflbk_low_i | input | 1 | Flyback polarity select (1 = active low) |
| line_stb_i | input | 1 | One-cycle pulse per scanline |
| disp_on_i | input | 1 | Requested final display state |
| fade_en_i | input | 1 | Use stepped fade instead of an immediate switch |
| color_i | input | CW | Overlay color from the character generator |
| color_o | output | CW | Gated overlay color |
| line_en_o | output | 1 | Current line is lit |
| busy_o | output | 1 | Fade in progress |

## Verification
The main function is exercised with a full fade-in and a full fade-out. Every line of a band is compared at each level and on the frame just before each step, which separates a correct 32-frame step length from an off-by-one and the bit-reversed line choice from a plain low-index choice. A reversal at level 2 shows whether the level continues from where it stands or restarts. An immediate on/off sequence with the request toggled between frames shows that the request is held until a frame start. A line-strobe run across a band end and an early frame start show that the line index wraps and is cleared at each frame. An active-low flyback run shows that only the active-going edge starts a frame.

// File: rtl/osd_fade_pkg.sv
package osd_fade_pkg;
  localparam int unsigned SEG_BITS_DEF    = 4;
  localparam int unsigned STEP_FRAMES_DEF = 32;
  localparam int unsigned COLOR_W_DEF     = 8;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } fade_dir_e;
endpackage

// File: rtl/osd_vsync_edge.sv
module osd_vsync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vflbk_i,
  input  logic vflbk_low_i,
  output logic frame_tick_o
);
  logic vf_act, vf_q;

  assign vf_act = vflbk_i ^ vflbk_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vf_q <= 1'b0;
    else         vf_q <= vf_act;
  end

  assign frame_tick_o = vf_act & ~vf_q;
endmodule

// File: rtl/osd_line_tracker.sv
module osd_line_tracker #(
  parameter int unsigned SEG_BITS = osd_fade_pkg::SEG_BITS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_tick_i,
  input  logic                line_stb_i,
  output logic [SEG_BITS-1:0] line_idx_o
);
  logic [SEG_BITS-1:0] idx_q;

  // frame start wins over a coincident strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idx_q <= '0;
    else if (frame_tick_i) idx_q <= '0;
    else if (line_stb_i)   idx_q <= idx_q + 1'b1;
  end

  assign line_idx_o = idx_q;
endmodule

// File: rtl/osd_fade_stepper.sv
module osd_fade_stepper #(
  parameter int unsigned SEG_BITS    = osd_fade_pkg::SEG_BITS_DEF,
  parameter int unsigned STEP_FRAMES = osd_fade_pkg::STEP_FRAMES_DEF,
  localparam int unsigned LVL_MAX    = SEG_BITS + 1,
  localparam int unsigned LW         = $clog2(LVL_MAX + 1),
  localparam int unsigned FW         = $clog2(STEP_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_tick_i,
  input  logic          disp_on_i,
  input  logic          fade_en_i,
  output logic [LW-1:0] lvl_o,
  output logic          busy_o
);
  import osd_fade_pkg::*;

  logic          on_q, on_d;
  logic [LW-1:0] lvl_q, lvl_d, tgt;
  logic [FW-1:0] fcnt_q, fcnt_d, fbase;
  fade_dir_e     dir;

  assign tgt   = disp_on_i ? LW'(LVL_MAX) : '0;
  // a new request restarts the frame count of the current step
  assign fbase = (disp_on_i != on_q) ? '0 : fcnt_q;

  always_comb begin
    if (lvl_q < tgt)      dir = DIR_UP;
    else if (lvl_q > tgt) dir = DIR_DOWN;
    else                  dir = DIR_HOLD;
  end

  always_comb begin
    on_d   = on_q;
    lvl_d  = lvl_q;
    fcnt_d = fcnt_q;
    if (frame_tick_i) begin
      on_d = disp_on_i;
      if (dir == DIR_HOLD) begin
        fcnt_d = '0;
      end else if (!fade_en_i) begin
        lvl_d  = tgt;
        fcnt_d = '0;
      end else if (fbase == FW'(STEP_FRAMES - 1)) begin
        fcnt_d = '0;
        lvl_d  = (dir == DIR_UP) ? lvl_q + 1'b1 : lvl_q - 1'b1;
      end else begin
        fcnt_d = fbase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      lvl_q  <= '0;
      fcnt_q <= '0;
    end else begin
      on_q   <= on_d;
      lvl_q  <= lvl_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign busy_o = lvl_q != (on_q ? LW'(LVL_MAX) : LW'(0));
endmodule

// File: rtl/osd_line_mask.sv
module osd_line_mask #(
  parameter int unsigned SEG_BITS = osd_fade_pkg::SEG_BITS_DEF,
  parameter int unsigned CW       = osd_fade_pkg::COLOR_W_DEF,
  localparam int unsigned LW      = $clog2(SEG_BITS + 2),
  localparam int unsigned CNT_W   = SEG_BITS + 1
) (
  input  logic [LW-1:0]       lvl_i,
  input  logic [SEG_BITS-1:0] line_idx_i,
  input  logic [CW-1:0]       color_i,
  output logic                line_en_o,
  output logic [CW-1:0]       color_o
);
  logic [SEG_BITS-1:0] idx_rev;
  logic [CNT_W-1:0]    lit_cnt;

  for (genvar b = 0; b < SEG_BITS; b++) begin : g_rev
    assign idx_rev[b] = line_idx_i[SEG_BITS-1-b];
  end

  assign lit_cnt   = (lvl_i == '0) ? '0 : CNT_W'(1) << (lvl_i - 1'b1);
  assign line_en_o = {1'b0, idx_rev} < lit_cnt;
  // dark lines drive zeros, never released
  assign color_o   = line_en_o ? color_i : '0;
endmodule

// File: rtl/osd_fade_seq.sv
module osd_fade_seq #(
  parameter int unsigned SEG_BITS    = osd_fade_pkg::SEG_BITS_DEF,
  parameter int unsigned STEP_FRAMES = osd_fade_pkg::STEP_FRAMES_DEF,
  parameter int unsigned CW          = osd_fade_pkg::COLOR_W_DEF,
  localparam int unsigned LW         = $clog2(SEG_BITS + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vflbk_i,
  input  logic          vflbk_low_i,
  input  logic          line_stb_i,
  input  logic          disp_on_i,
  input  logic          fade_en_i,
  input  logic [CW-1:0] color_i,
  output logic [CW-1:0] color_o,
  output logic          line_en_o,
  output logic          busy_o
);
  logic                frame_tick;
  logic [SEG_BITS-1:0] line_idx;
  logic [LW-1:0]       lvl;

  osd_vsync_edge u_vsync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vflbk_i      (vflbk_i),
    .vflbk_low_i  (vflbk_low_i),
    .frame_tick_o (frame_tick)
  );

  osd_line_tracker #(.SEG_BITS(SEG_BITS)) u_lines (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_tick_i (frame_tick),
    .line_stb_i   (line_stb_i),
    .line_idx_o   (line_idx)
  );

  osd_fade_stepper #(.SEG_BITS(SEG_BITS), .STEP_FRAMES(STEP_FRAMES)) u_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_tick_i (frame_tick),
    .disp_on_i    (disp_on_i),
    .fade_en_i    (fade_en_i),
    .lvl_o        (lvl),
    .busy_o       (busy_o)
  );

  osd_line_mask #(.SEG_BITS(SEG_BITS), .CW(CW)) u_mask (
    .lvl_i      (lvl),
    .line_idx_i (line_idx),
    .color_i    (color_i),
    .line_en_o  (line_en_o),
    .color_o    (color_o)
  );
endmodule

// File: rtl/osd_fade_seq_chk.sv
module osd_fade_seq_chk #(
  parameter int unsigned SEG_BITS = 4,
  parameter int unsigned CW       = 8,
  localparam int unsigned LVL_MAX = SEG_BITS + 1,
  localparam int unsigned LW      = $clog2(SEG_BITS + 2)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_tick_i,
  input logic                fade_en_i,
  input logic [LW-1:0]       lvl_i,
  input logic [SEG_BITS-1:0] line_idx_i,
  input logic                line_en_o,
  input logic [CW-1:0]       color_o,
  input logic                busy_o
);
  AST_LVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= LW'(LVL_MAX)); // R4

  AST_DARK_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i == '0 |-> !line_en_o && color_o == '0); // R11

  AST_LIT_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i == LW'(LVL_MAX) |-> line_en_o); // R4

  AST_LINE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_i |=> line_idx_i == '0); // R3

  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(lvl_i)); // R8

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_i && fade_en_i |=> (lvl_i == $past(lvl_i)) ||
      (lvl_i == $past(lvl_i) + 1'b1) || ($past(lvl_i) == lvl_i + 1'b1)); // R5

  AST_IDLE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> lvl_i == '0 || lvl_i == LW'(LVL_MAX)); // R10
endmodule

bind osd_fade_seq osd_fade_seq_chk #(.SEG_BITS(SEG_BITS), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_tick_i (frame_tick),
  .fade_en_i    (fade_en_i),
  .lvl_i        (lvl),
  .line_idx_i   (line_idx),
  .line_en_o    (line_en_o),
  .color_o      (color_o),
  .busy_o       (busy_o)
);

// File: tb/osd_fade_seq_bench.sv
`timescale 1ns/1ps
module osd_fade_seq_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vflbk = 1'b0, vflbk_low = 1'b0, line_stb = 1'b0;
  logic          disp_on = 1'b0, fade_en = 1'b0;
  logic [CW-1:0] color_in = 8'hA5;
  logic [CW-1:0] color_out;
  logic          line_en, busy;

  always #2.5 clk = ~clk;

  osd_fade_seq u_osd_fade_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vflbk_i     (vflbk),
    .vflbk_low_i (vflbk_low),
    .line_stb_i  (line_stb),
    .disp_on_i   (disp_on),
    .fade_en_i   (fade_en),
    .color_i     (color_in),
    .color_o     (color_out),
    .line_en_o   (line_en),
    .busy_o      (busy)
  );

  typedef struct {
    string tag;
    logic  en;
    logic  bsy;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  // monitor: one item per negedge after the driver queues it
  initial forever begin
    item_t         it;
    logic [CW-1:0] exp_col;
    wait (q.size() > 0);
    @(negedge clk);
    it      = q.pop_front();
    exp_col = it.en ? color_in : '0;
    n_chk++;
    if (line_en !== it.en || busy !== it.bsy || color_out !== exp_col) begin
      n_fail++;
      $display("FAIL %s: en/busy/color act %b/%b/%h exp %b/%b/%h",
               it.tag, line_en, busy, color_out, it.en, it.bsy, exp_col);
    end
  end

  function automatic logic exp_en(int lvl, int idx);
    int rev = 0;
    int cnt;
    for (int b = 0; b < 4; b++) if (((idx >> b) & 1) != 0) rev |= 1 << (3 - b);
    cnt = (lvl == 0) ? 0 : (1 << (lvl - 1));
    return rev < cnt;
  endfunction

  task automatic expect_now(string tag, logic en, logic bsy);
    item_t it;
    it.tag = tag; it.en = en; it.bsy = bsy;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic stb();
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
  endtask

  task automatic frame();
    vflbk = ~vflbk_low;
    @(negedge clk);
    @(negedge clk);
    vflbk = vflbk_low;
    @(negedge clk);
  endtask

  // line index is 0 on entry; walks all 16 lines and the wrap
  task automatic check_mask(string tag, int lvl, logic bsy);
    for (int k = 0; k < 16; k++) begin
      expect_now(tag, exp_en(lvl, k), bsy);
      stb();
    end
    expect_now({tag, " R3 wrap"}, exp_en(lvl, 0), bsy);
  endtask

  initial begin
    #(5 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act hung exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 held in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 after reset", 1'b0, 1'b0);

    // fade-in
    disp_on = 1'b1; fade_en = 1'b1;
    stb();
    expect_now("R8 request not yet latched", 1'b0, 1'b0);
    frame();
    for (int n = 1; n <= 160; n++) begin
      if (n > 1) frame();
      if (n == 1)  expect_now("R10 busy on start", 1'b0, 1'b1);
      if (n == 31) check_mask("R5 level 0 at frame 31", 0, 1'b1);
      if (n == 32) begin
        check_mask("R5 level 1", 1, 1'b1);
        repeat (5) stb();
        expect_now("R3 index 5 dark", 1'b0, 1'b1);
      end
      if (n == 33) expect_now("R3 index cleared by frame", 1'b1, 1'b1);
      if (n % 32 == 0 && n > 32) check_mask("R5 level step", n / 32, n != 160);
    end

    // fade-out
    color_in = 8'h3C;
    disp_on = 1'b0;
    for (int n = 1; n <= 160; n++) begin
      frame();
      if (n == 31) check_mask("R6 hold at 0 blanked", 5, 1'b1);
      if (n % 32 == 0) check_mask("R6 blank step", 5 - n / 32, n != 160);
    end

    // reversal from level 2
    disp_on = 1'b1;
    for (int n = 1; n <= 64; n++) frame();
    check_mask("R9 setup level 2", 2, 1'b1);
    disp_on = 1'b0;
    frame();
    check_mask("R9 reversal keeps level", 2, 1'b1);
    for (int n = 2; n <= 31; n++) frame();
    check_mask("R9 level 2 at frame 31", 2, 1'b1);
    frame();
    check_mask("R9 stepped down", 1, 1'b1);
    for (int n = 1; n <= 32; n++) frame();
    check_mask("R9 back to dark", 0, 1'b0);

    // immediate switching
    fade_en = 1'b0; disp_on = 1'b1;
    repeat (3) stb();
    expect_now("R8 on held until frame", 1'b0, 1'b0);
    frame();
    check_mask("R7 immediate on", 5, 1'b0);
    disp_on = 1'b0;
    stb();
    expect_now("R8 off held until frame", 1'b1, 1'b0);
    frame();
    check_mask("R7 immediate off", 0, 1'b0);

    // active-low flyback
    vflbk_low = 1'b1; vflbk = 1'b1; disp_on = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_now("R2 polarity change no frame", 1'b0, 1'b0);
    vflbk = 1'b0;
    @(negedge clk); @(negedge clk);
    expect_now("R2 falling edge starts frame", 1'b1, 1'b0);
    disp_on = 1'b0;
    vflbk = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_now("R2 release edge ignored", 1'b1, 1'b0);
    vflbk = 1'b0;
    @(negedge clk);
    expect_now("R2 next falling edge", 1'b0, 1'b0);
    vflbk = 1'b1;
    @(negedge clk);

    // reset while lit
    disp_on = 1'b1;
    frame();
    expect_now("R11 lit before reset", 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    expect_now("R1 async reset clears", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule